// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block turns one read or write command into the list of column addresses that the burst touches. A mode write loads two settings: a 3-bit length code and an ordering bit. When a command arrives with its starting column, the block emits two column addresses per clock. The rise lane carries the even beat of the pair and the fall lane carries the odd beat. This matches a double data rate transfer, which moves one word on each clock edge.

Addresses stay inside a column block whose size equals the burst length and whose base is aligned to that size. The low bits wrap inside the block and never carry into the bits above it. Beats run either in counting order or in XOR order. A truncate input ends the burst early, and a new command replaces the running burst. The final pair of a burst that runs to completion is marked with a last flag.

The controller has two states. IDLE waits for a command. BURST emits one pair per cycle. The transitions are:
- IDLE to BURST when a command is accepted.
- BURST to BURST when it advances to the next pair, or when a new command restarts the burst.
- BURST to IDLE after the final pair, or on truncate.

Top module: `ddr_burst_colseq`

## Requirements
- R1: The length code selects the beats per burst: 3'b001 gives 2 beats, 3'b010 gives 4 beats and 3'b011 gives 8 beats. A burst of N beats shows `beat_valid` for exactly N/2 consecutive cycles.
- R2: When the order bit is 0, beat i of a burst addresses low bits (start + i) mod N, where start is the low bits of the command column.
- R3: When the order bit is 1, beat i addresses low bits start XOR i.
- R4: On every beat, the column bits at and above log2(N) equal those of the command column, so a wrap never carries upward.
- R5: In the first cycle after the clock edge that samples `cmd_start`, `col_rise` equals `cmd_col` exactly. Each cycle, `col_rise` carries beat 2k and `col_fall` carries beat 2k+1.
- R6: `last_beat` is high only together with `beat_valid`, and only in the final cycle of a burst that runs to completion.
- R7: If `trunc` is high at an edge during a burst and no command is given at that edge, the next cycle has neither `beat_valid` nor `last_beat`.
- R8: A command given during a burst abandons that burst. The next cycle starts the new burst at the new column.
- R9: A mode write with a reserved length code (3'b000 or 3'b1xx) raises `cfg_err`. While `cfg_err` is high, commands produce no beats.
- R10: A mode write presented while a burst is running, or in the same cycle as a command, is ignored. The earlier settings stay in force.
- R11: After reset, `beat_valid`, `last_beat` and `cfg_err` are low, and the mode is 4 beats in counting order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Mode write strobe |
| cfg_len_code | input | 3 | Burst length code |
| cfg_order | input | 1 | 0 for counting order, 1 for XOR order |
| cmd_start | input | 1 | Read or write command strobe |
| cmd_col | input | COL_W | Starting column of the command |
| trunc | input | 1 | Stop the running burst |
| beat_valid | output | 1 | Address pair is valid this cycle |
| col_rise | output | COL_W | Column of the even beat |
| col_fall | output | COL_W | Column of the odd beat |
| last_beat | output | 1 | Final pair of a completed burst |
| cfg_err | output | 1 | Stored length code is reserved |

## Verification
The bench targets the wrap points. These include a start at the top of a block, such as column 0x007 in an 8-beat burst, and a start at the all-ones column. A design that carried out of the block would step into the next column block. A design that swapped the counting and XOR formulas would show the odd-start patterns in the wrong order. The bench also checks that truncate and restart end the old burst on the next cycle. A late stop would show an extra pair or a stray last flag. Finally, it checks that a mode write during a burst is ignored. A design that took the write would shorten the following burst.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

    localparam int LOW_W = 3;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_t;

    // Low-bit mask for a length code; zero marks a reserved code.
    function automatic logic [LOW_W-1:0] len_mask(input logic [2:0] code);
        unique case (code)
            3'b001:  len_mask = 3'b001;
            3'b010:  len_mask = 3'b011;
            3'b011:  len_mask = 3'b111;
            default: len_mask = 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/colseq_cfg.sv
module colseq_cfg
    import colseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             busy,
    input  logic [2:0]       code_in,
    input  logic             order_in,
    output logic [LOW_W-1:0] mask,
    output logic             order,
    output logic             err
);

    logic [2:0] code_q;
    logic       order_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= 3'b010;
            order_q <= 1'b0;
        end else if (load && !busy) begin
            code_q  <= code_in;
            order_q <= order_in;
        end
    end

    always_comb begin
        mask  = len_mask(code_q);
        order = order_q;
        err   = (mask == '0);
    end

    // R10: settings never move while the sequencer is busy
    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(code_q) && $stable(order_q));

endmodule

// File: rtl/colseq_order.sv
module colseq_order
    import colseq_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int LANE  = 0
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [LOW_W-1:0] mask,
    input  logic             order,
    input  logic [1:0]       pair_idx,
    output logic [COL_W-1:0] col
);

    logic [LOW_W-1:0] beat;
    logic [LOW_W-1:0] low;
    logic [COL_W-1:0] keep_mask;

    always_comb begin
        beat      = {pair_idx, LANE[0]};
        low       = order ? (base_col[LOW_W-1:0] ^ beat)
                          : (base_col[LOW_W-1:0] + beat);
        keep_mask = {{(COL_W-LOW_W){1'b1}}, ~mask};
        col       = (base_col & keep_mask) | {{(COL_W-LOW_W){1'b0}}, low & mask};
    end

endmodule

// File: rtl/ddr_burst_colseq.sv
module ddr_burst_colseq
    import colseq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [2:0]       cfg_len_code,
    input  logic             cfg_order,
    input  logic             cmd_start,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             trunc,
    output logic             beat_valid,
    output logic [COL_W-1:0] col_rise,
    output logic [COL_W-1:0] col_fall,
    output logic             last_beat,
    output logic             cfg_err
);

    localparam int LANES = 2;

    seq_state_t       state_q, state_d;
    logic [1:0]       idx_q, idx_d;
    logic [COL_W-1:0] base_q, base_d;
    logic [LOW_W-1:0] mask;
    logic             order;
    logic [1:0]       last_idx;
    logic             accept;
    logic             busy;
    logic [COL_W-1:0] lane_col [LANES];

    assign busy = (state_q == ST_BURST) || cmd_start;

    colseq_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .busy     (busy),
        .code_in  (cfg_len_code),
        .order_in (cfg_order),
        .mask     (mask),
        .order    (order),
        .err      (cfg_err)
    );

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            colseq_order #(.COL_W(COL_W), .LANE(g)) u_order (
                .base_col (base_q),
                .mask     (mask),
                .order    (order),
                .pair_idx (idx_q),
                .col      (lane_col[g])
            );
        end
    endgenerate

    assign last_idx = mask[2:1];
    assign accept   = cmd_start && !cfg_err;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        base_d  = base_q;
        if (accept) begin
            state_d = ST_BURST;
            idx_d   = 2'd0;
            base_d  = cmd_col;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_BURST: begin
                    if (trunc || idx_q == last_idx) begin
                        state_d = ST_IDLE;
                    end else begin
                        idx_d = idx_q + 2'd1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= 2'd0;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            base_q  <= base_d;
        end
    end

    always_comb begin
        beat_valid = (state_q == ST_BURST);
        last_beat  = beat_valid && (idx_q == last_idx);
        col_rise   = lane_col[0];
        col_fall   = lane_col[1];
    end

    // R5: the first even beat is the command column itself
    assert_first_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !cfg_err) |=> beat_valid && (col_rise == $past(cmd_col)));

    // R4: both lanes share the same block above the wrap bits
    assert_same_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> ((col_rise >> LOW_W) == (col_fall >> LOW_W)));

    // R2/R3: the two beats of a pair never alias
    assert_lanes_differ_R3: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (col_rise != col_fall));

    // R6: nothing follows the last pair unless a new command arrives
    assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !cmd_start) |=> !beat_valid);

    // R7: truncation stops the burst on the next cycle
    assert_trunc_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && trunc && !cmd_start) |=> !beat_valid && !last_beat);

    // R9: a reserved mode never yields beats
    assert_err_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !beat_valid);

endmodule

// File: tb/ddr_burst_colseq_tb.sv
module ddr_burst_colseq_tb;

    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_load = 1'b0;
    logic [2:0]       cfg_len_code = 3'b010;
    logic             cfg_order = 1'b0;
    logic             cmd_start = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic             trunc = 1'b0;
    logic             beat_valid;
    logic [COL_W-1:0] col_rise;
    logic [COL_W-1:0] col_fall;
    logic             last_beat;
    logic             cfg_err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    ddr_burst_colseq #(.COL_W(COL_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_load     (cfg_load),
        .cfg_len_code (cfg_len_code),
        .cfg_order    (cfg_order),
        .cmd_start    (cmd_start),
        .cmd_col      (cmd_col),
        .trunc        (trunc),
        .beat_valid   (beat_valid),
        .col_rise     (col_rise),
        .col_fall     (col_fall),
        .last_beat    (last_beat),
        .cfg_err      (cfg_err)
    );

    // {code[2:0], order, col[9:0], expected low 3 bits of beats 0..7}
    localparam int NV = 8;
    localparam logic [37:0] VEC [NV] = '{
        {3'b011, 1'b0, 10'h0F5, 3'd5,3'd6,3'd7,3'd0,3'd1,3'd2,3'd3,3'd4},
        {3'b011, 1'b1, 10'h0F5, 3'd5,3'd4,3'd7,3'd6,3'd1,3'd0,3'd3,3'd2},
        {3'b010, 1'b0, 10'h1A6, 3'd6,3'd7,3'd4,3'd5,3'd0,3'd0,3'd0,3'd0},
        {3'b010, 1'b1, 10'h1A5, 3'd5,3'd4,3'd7,3'd6,3'd0,3'd0,3'd0,3'd0},
        {3'b001, 1'b0, 10'h3FF, 3'd7,3'd6,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0},
        {3'b001, 1'b1, 10'h200, 3'd0,3'd1,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0},
        {3'b011, 1'b0, 10'h007, 3'd7,3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6},
        {3'b010, 1'b0, 10'h003, 3'd3,3'd0,3'd1,3'd2,3'd0,3'd0,3'd0,3'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] code, input logic ord);
        @(negedge clk);
        cfg_load = 1'b1; cfg_len_code = code; cfg_order = ord;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // issue a command; returns at the negedge inside the first burst cycle
    task automatic issue(input logic [COL_W-1:0] col);
        cmd_start = 1'b1; cmd_col = col;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        #1;
        check("R11 valid in reset", beat_valid, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 valid", beat_valid, 0);
        check("R11 last", last_beat, 0);
        check("R11 err", cfg_err, 0);
        issue(10'h001);
        check("R11 default start", col_rise, 10'h001);
        check("R11 default order", col_fall, 10'h002);
        @(negedge clk);
        check("R11 default length 4", last_beat, 1);
        check("R11 default last addr", col_fall, 10'h000);
        @(negedge clk);
        check("R11 ends", beat_valid, 0);

        // table walk: R1 R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            logic [2:0]       code;
            logic [COL_W-1:0] col;
            int               ncyc;
            code = VEC[v][37:35];
            col  = VEC[v][33:24];
            ncyc = (code == 3'b001) ? 1 : (code == 3'b010) ? 2 : 4;
            set_mode(code, VEC[v][34]);
            issue(col);
            for (int c = 0; c < ncyc; c++) begin
                logic [2:0] er, ef;
                er = VEC[v][23 - 6*c -: 3];
                ef = VEC[v][20 - 6*c -: 3];
                check("R1 valid", beat_valid, 1);
                check(VEC[v][34] ? "R3 rise col" : "R2 rise col", col_rise, {col[COL_W-1:3], er});
                check(VEC[v][34] ? "R3 fall col R4" : "R2 fall col R4", col_fall, {col[COL_W-1:3], ef});
                check("R6 last flag", last_beat, (c == ncyc - 1));
                @(negedge clk);
            end
            check("R1 burst ended", beat_valid, 0);
        end

        // R7 truncate after first pair of an 8-beat burst
        set_mode(3'b011, 1'b0);
        issue(10'h040);
        trunc = 1'b1;
        @(negedge clk);
        trunc = 1'b0;
        check("R7 valid after trunc", beat_valid, 0);
        check("R7 no last", last_beat, 0);

        // R8 restart during a burst
        issue(10'h010);
        check("R8 first burst", col_rise, 10'h010);
        issue(10'h023);
        check("R8 new rise", col_rise, 10'h023);
        check("R8 new fall", col_fall, 10'h024);
        repeat (3) @(negedge clk);
        check("R8 new last", last_beat, 1);
        @(negedge clk);

        // R10 mode write during a burst ignored
        issue(10'h080);
        cfg_load = 1'b1; cfg_len_code = 3'b001; cfg_order = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        repeat (3) @(negedge clk);
        issue(10'h081);
        check("R10 order kept", col_fall, 10'h082);
        check("R10 no early last", last_beat, 0);
        repeat (3) @(negedge clk);
        check("R10 length kept", last_beat, 1);
        @(negedge clk);

        // R9 reserved codes
        set_mode(3'b000, 1'b0);
        check("R9 err 000", cfg_err, 1);
        issue(10'h005);
        check("R9 no beats", beat_valid, 0);
        set_mode(3'b101, 1'b0);
        check("R9 err 101", cfg_err, 1);
        issue(10'h006);
        check("R9 no beats 101", beat_valid, 0);
        set_mode(3'b001, 1'b0);
        check("R9 err cleared", cfg_err, 0);
        issue(10'h006);
        check("R9 beats resume", col_fall, 10'h007);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule